// File: doc/BRIEF.md
# E1 Receive Channel Timing Generator

This block derives the per-bit, per-channel and per-frame timing strobes for the receive side of a 2.048 Mbit/s E1 link. It runs from the bit clock and counts bit position within a channel (8 bits, MSB first), channel within a frame (32 channels) and frame within a 16-frame multiframe. An alignment pulse reloads the counters to the start of a multiframe. A second reference pulse sets the phase of CRC4 multiframes.

Downstream logic uses the outputs in these ways. A channel strobe marks the last bit of each channel, for serial-to-parallel conversion. A per-channel gate follows a 32-bit host mask, so a controller can be clocked only on the timeslots of a fractional service. A frame pulse marks each frame. A selectable pulse marks either frames or multiframes. A multiframe pulse follows either CAS or CRC4 alignment.

A host writes the mask and the mode bits through a single write port. Writes are staged, and the new values take effect only at the next frame boundary. This keeps the gate from changing partway through a frame.

Top module: `e1_rx_timing`

## Requirements
- R1: While rst_ni is low, and until the first clock edge after release, every output is 0. After reset the channel mask and both mode bits are 0.
- R2: chan_clk_o is 1 exactly when the bit index within the current channel is 7, which is the last bit of the channel. It is high one cycle in every eight.
- R3: chan_blk_o equals bit n of the active channel mask while channel n is being received. Mask bit 0 belongs to channel 0.
- R4: frame_sync_o is a one-cycle pulse at bit 0 of channel 0 of every frame, once every 256 cycles.
- R5: When active mode bit 0 is 0, sel_sync_o equals frame_sync_o. When it is 1, sel_sync_o equals mf_sync_o.
- R6: When active mode bit 1 is 0 (CAS), mf_sync_o pulses at the frame boundary of frame 0 of the 16-frame counter.
- R7: When active mode bit 1 is 1 (CRC4), mf_sync_o pulses at the frame boundary of frame F. F is the frame index of the position that follows the most recent cycle in which crc_mf_i was high, and it is 0 after reset.
- R8: A high sync_i makes the position in the next cycle bit 0, channel 0, frame 0.
- R9: A write with wr_addr_i=0 stages the mask. A write with wr_addr_i=1 stages the mode bits, with wr_data_i[0] as the sync select and wr_data_i[1] as the CRC4 select. Staged values become active only on entry to the next frame boundary, and the active values do not change at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Alignment pulse, reloads counters |
| crc_mf_i | input | 1 | CRC4 multiframe reference pulse |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 1 | 0 selects the mask, 1 selects the mode |
| wr_data_i | input | 32 | Write data |
| chan_clk_o | output | 1 | Last-bit-of-channel strobe |
| chan_blk_o | output | 1 | Per-channel gate |
| frame_sync_o | output | 1 | Frame boundary pulse |
| sel_sync_o | output | 1 | Frame-or-multiframe pulse |
| mf_sync_o | output | 1 | Multiframe boundary pulse |

## Verification
Free-running stretches with a zero mask and default mode show the counter cadence alone. They separate an off-by-one bit or channel decode from an error in frame wrap. Sparse and dense masks are written partway through a frame. One is a six-slot fractional pattern and the other has every slot set except slot 0. These show whether the gate follows the channel index and whether the update waits for the frame boundary. Sync pulses arrive both mid-frame and back to back, and CRC4 reference pulses fall at arbitrary offsets. Together they distinguish CAS from CRC4 multiframe placement and test the reload priority over normal counting.

// File: rtl/e1_rx_pkg.sv
package e1_rx_pkg;
  parameter int unsigned CHAN_BITS = 8;
  parameter int unsigned NUM_CHAN  = 32;
  parameter int unsigned MF_FRAMES = 16;

  localparam int unsigned BIT_W  = $clog2(CHAN_BITS);
  localparam int unsigned CHAN_W = $clog2(NUM_CHAN);
  localparam int unsigned FRM_W  = $clog2(MF_FRAMES);
  localparam int unsigned MODE_W = 2;

  typedef struct packed {
    logic [FRM_W-1:0]  frm;
    logic [CHAN_W-1:0] chan;
    logic [BIT_W-1:0]  bit_idx;
  } pos_t;

  typedef struct packed {
    logic [NUM_CHAN-1:0] mask;
    logic                mf_crc;
    logic                sync_mf;
  } cfg_t;
endpackage

// File: rtl/e1_rx_cnt.sv
module e1_rx_cnt
  import e1_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output pos_t pos_q_o,
  output pos_t pos_d_o,
  output logic bnd_d_o
);
  localparam logic [BIT_W-1:0]  BIT_MAX  = BIT_W'(CHAN_BITS - 1);
  localparam logic [CHAN_W-1:0] CHAN_MAX = CHAN_W'(NUM_CHAN - 1);
  localparam logic [FRM_W-1:0]  FRM_MAX  = FRM_W'(MF_FRAMES - 1);

  pos_t pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (sync_i) begin
      pos_d = '0;
    end else if (pos_q.bit_idx != BIT_MAX) begin
      pos_d.bit_idx = pos_q.bit_idx + 1'b1;
    end else begin
      pos_d.bit_idx = '0;
      if (pos_q.chan != CHAN_MAX) begin
        pos_d.chan = pos_q.chan + 1'b1;
      end else begin
        pos_d.chan = '0;
        pos_d.frm  = (pos_q.frm == FRM_MAX) ? '0 : pos_q.frm + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;
  end

  assign pos_q_o = pos_q;
  assign pos_d_o = pos_d;
  assign bnd_d_o = (pos_d.bit_idx == '0) && (pos_d.chan == '0);

  // R8
  sync_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (pos_q.bit_idx == '0 && pos_q.chan == '0 && pos_q.frm == '0));

  // R2
  bit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && pos_q.bit_idx != BIT_MAX) |=> (pos_q.bit_idx == $past(pos_q.bit_idx) + 1'b1));
endmodule

// File: rtl/e1_rx_cfg.sv
module e1_rx_cfg
  import e1_rx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                wr_addr_i,
  input  logic [NUM_CHAN-1:0] wr_data_i,
  input  logic                bnd_d_i,
  output cfg_t                cfg_d_o
);
  cfg_t stage_q, stage_d, act_q, act_d;

  always_comb begin
    stage_d = stage_q;
    if (wr_en_i) begin
      if (!wr_addr_i) stage_d.mask = wr_data_i;
      else            {stage_d.mf_crc, stage_d.sync_mf} = wr_data_i[MODE_W-1:0];
    end
    act_d = bnd_d_i ? stage_d : act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      stage_q <= stage_d;
      act_q   <= act_d;
    end
  end

  assign cfg_d_o = act_d;

  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd_d_i |=> $stable(act_q));
endmodule

// File: rtl/e1_rx_strobe.sv
module e1_rx_strobe
  import e1_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  pos_t pos_d_i,
  input  cfg_t cfg_d_i,
  input  logic crc_mf_i,
  output logic chan_clk_o,
  output logic chan_blk_o,
  output logic frame_sync_o,
  output logic sel_sync_o,
  output logic mf_sync_o
);
  localparam logic [BIT_W-1:0] BIT_MAX = BIT_W'(CHAN_BITS - 1);

  logic [FRM_W-1:0] crc_ofs_q, crc_ofs_d;
  logic frm_start_d, mf_hit_d, mf_d;

  assign crc_ofs_d   = crc_mf_i ? pos_d_i.frm : crc_ofs_q;
  assign frm_start_d = (pos_d_i.bit_idx == '0) && (pos_d_i.chan == '0);
  assign mf_hit_d    = cfg_d_i.mf_crc ? (pos_d_i.frm == crc_ofs_d) : (pos_d_i.frm == '0);
  assign mf_d        = frm_start_d && mf_hit_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_ofs_q    <= '0;
      chan_clk_o   <= 1'b0;
      chan_blk_o   <= 1'b0;
      frame_sync_o <= 1'b0;
      sel_sync_o   <= 1'b0;
      mf_sync_o    <= 1'b0;
    end else begin
      crc_ofs_q    <= crc_ofs_d;
      chan_clk_o   <= (pos_d_i.bit_idx == BIT_MAX);
      chan_blk_o   <= cfg_d_i.mask[pos_d_i.chan];
      frame_sync_o <= frm_start_d;
      sel_sync_o   <= cfg_d_i.sync_mf ? mf_d : frm_start_d;
      mf_sync_o    <= mf_d;
    end
  end

  // R2
  chan_clk_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_clk_o |=> !chan_clk_o);
  // R6
  mf_on_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mf_sync_o |-> frame_sync_o);
  // R5
  sel_sub_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_sync_o |-> frame_sync_o);
endmodule

// File: rtl/e1_rx_timing.sv
module e1_rx_timing
  import e1_rx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sync_i,
  input  logic                crc_mf_i,
  input  logic                wr_en_i,
  input  logic                wr_addr_i,
  input  logic [NUM_CHAN-1:0] wr_data_i,
  output logic                chan_clk_o,
  output logic                chan_blk_o,
  output logic                frame_sync_o,
  output logic                sel_sync_o,
  output logic                mf_sync_o
);
  pos_t pos_q, pos_d;
  logic bnd_d;
  cfg_t cfg_d;

  e1_rx_cnt u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_i),
    .pos_q_o (pos_q),
    .pos_d_o (pos_d),
    .bnd_d_o (bnd_d)
  );

  e1_rx_cfg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .bnd_d_i   (bnd_d),
    .cfg_d_o   (cfg_d)
  );

  e1_rx_strobe u_strobe (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pos_d_i      (pos_d),
    .cfg_d_i      (cfg_d),
    .crc_mf_i     (crc_mf_i),
    .chan_clk_o   (chan_clk_o),
    .chan_blk_o   (chan_blk_o),
    .frame_sync_o (frame_sync_o),
    .sel_sync_o   (sel_sync_o),
    .mf_sync_o    (mf_sync_o)
  );

  // R4
  frame_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_sync_o && !sync_i) |=> !frame_sync_o);

  // R4
  frame_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sync_o |-> (pos_q.bit_idx == '0 && pos_q.chan == '0));
endmodule

// File: tb/e1_rx_timing_test.sv
`timescale 1ns/1ps
module e1_rx_timing_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync = 1'b0, crc_mf = 1'b0, wr_en = 1'b0, wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic chan_clk, chan_blk, frame_sync, sel_sync, mf_sync;

  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  e1_rx_timing uut (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .crc_mf_i(crc_mf),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .chan_clk_o(chan_clk), .chan_blk_o(chan_blk), .frame_sync_o(frame_sync),
    .sel_sync_o(sel_sync), .mf_sync_o(mf_sync)
  );

  // reference model: linear position 0..4095 within a multiframe
  int pos = 0, crc_ofs = 0;
  logic [31:0] st_mask = '0, act_mask = '0;
  logic [1:0]  st_mode = '0, act_mode = '0;
  logic started = 1'b0;
  logic e_clk = 0, e_blk = 0, e_frm = 0, e_sel = 0, e_mf = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos = 0; crc_ofs = 0; st_mask = '0; act_mask = '0;
      st_mode = '0; act_mode = '0; started = 1'b0;
      e_clk = 0; e_blk = 0; e_frm = 0; e_sel = 0; e_mf = 0;
    end else begin
      int frm, ch, b;
      logic hit;
      cycles++;
      pos = sync ? 0 : (pos + 1) % 4096;
      frm = pos / 256; ch = (pos / 8) % 32; b = pos % 8;
      if (crc_mf) crc_ofs = frm;
      if (wr_en) begin
        if (wr_addr) st_mode = wr_data[1:0];
        else         st_mask = wr_data;
      end
      if (pos % 256 == 0) begin
        act_mask = st_mask;
        act_mode = st_mode;
      end
      hit   = act_mode[1] ? (frm == crc_ofs) : (frm == 0);
      e_clk = (b == 7);
      e_blk = act_mask[ch];
      e_frm = (pos % 256 == 0);
      e_mf  = e_frm && hit;
      e_sel = act_mode[0] ? e_mf : e_frm;
      started = 1'b1;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d pos %0d: actual %0b expected %0b", req, cycles, pos, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n || !started) begin
      // R1: all strobes low in reset and before first edge
      chk("R1 chan_clk", chan_clk, 1'b0);
      chk("R1 chan_blk", chan_blk, 1'b0);
      chk("R1 frame_sync", frame_sync, 1'b0);
      chk("R1 sel_sync", sel_sync, 1'b0);
      chk("R1 mf_sync", mf_sync, 1'b0);
    end else begin
      chk("R2 chan_clk", chan_clk, e_clk);
      chk("R3 R9 chan_blk", chan_blk, e_blk);
      chk("R4/R8 frame_sync", frame_sync, e_frm);
      chk("R5 sel_sync", sel_sync, e_sel);
      chk(act_mode[1] ? "R7 mf_sync" : "R6 mf_sync", mf_sync, e_mf);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_sync();
    @(negedge clk); sync = 1'b1;
    @(negedge clk); sync = 1'b0;
    // R8: position restarts at the frame boundary
    chk("R8 direct", frame_sync, 1'b1);
  endtask

  task automatic pulse_crc();
    @(negedge clk); crc_mf = 1'b1;
    @(negedge clk); crc_mf = 1'b0;
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(600);                    // R2 R4 R6 free run
    write(1'b0, 32'h0000_007E);   // R3 R9 fractional mask mid-frame
    idle(700);
    write(1'b0, 32'hFFFF_FFFE);   // R3 dense mask
    idle(400);
    write(1'b1, 32'h1);           // R5 sync select multiframe, CAS
    idle(4500);
    pulse_sync();                 // R8 mid-frame reload
    idle(300);
    @(negedge clk); sync = 1'b1;  // R8 back-to-back
    idle(3);
    sync = 1'b0;
    idle(200);
    write(1'b1, 32'h3);           // R7 CRC4 multiframe
    idle(1000);
    pulse_crc();
    idle(4400);
    repeat (3) begin
      idle(137);
      pulse_crc();
    end
    idle(4300);
    write(1'b1, 32'h2);           // R5 frame select with CRC4
    write(1'b0, 32'h8000_0001);
    idle(1200);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule